// File: doc/BRIEF.md
# T1/E1 Loopback and Receive Conditioning Datapath

This block is the per-port bit-serial steering stage of a T1/E1 framer. It sits between the line interface, the outputs of the receive framer and the inputs of the transmit framer. On the receive side it can invert one class of bits, chosen from framing, signaling or payload. It can also hold the receive serial output high while frame alignment is lost. Framing, CRC generation and line coding are done by neighbouring logic. This block only steers bits and selects clocks.

The block provides two test loopbacks. Payload loopback sends received payload bits, with bipolar violations already corrected, into the transmit framer. The transmit framer then regenerates all overhead. The transmit frame sync and the transmit bit clock follow the receiver, and the channel clock and channel block outputs are held low. Framer loopback routes the line-formatted transmit stream into the receive framer and moves receive timing onto the transmit clock. The line output then carries all ones in T1 mode and normal transmit data in E1 mode. If both loopbacks are requested, framer loopback wins and a conflict flag is raised.

Every output except the loopback window counter is combinational. The counter advances on the system clock in cycles where the receive bit-time strobe is high.

Top module: `t1e1_loop_cond`

## Requirements
- R1: `cfg_inv_sel` chooses the bit class to invert on `rx_ser_out`: 2'b00 inverts nothing, 2'b01 inverts bits with `rx_cls_frm`, 2'b10 inverts bits with `rx_cls_sig`, 2'b11 inverts bits with `rx_cls_pay`. Bits of any other class pass through unchanged.
- R2: When `cfg_lof_force`=1 and `rx_lof`=1, `rx_ser_out` is 1 whatever the data and inversion setting.
- R3: When `cfg_lof_force`=0, `rx_lof` has no effect on `rx_ser_out`.
- R4: In payload loopback, `tx_framer_in` carries `rx_fr_bit` (not inverted) on payload bits inside the frame window and 1 on all other bits. `tx_ser_in`, `tx_sig_in` and `tx_sig_ins` are ignored.
- R5: The loopback window holds the first 192 payload bits of a frame when `cfg_e1`=0 and the first 248 when `cfg_e1`=1. The bit with `rx_fsync`=1 is payload index 0. The count advances only in cycles with `rx_bit_en`=1. Payload bits beyond the window are sent as 1.
- R6: In payload loopback, `tx_fsync_out` follows `rx_fsync` and `tx_clk_sel_rx`=1. Otherwise `tx_fsync_out` follows `tx_fsync_in` and `tx_clk_sel_rx`=0.
- R7: In payload loopback, `tx_chclk_out` and `tx_chblk_out` are 0. Otherwise they follow `tx_chclk_in` and `tx_chblk_in`.
- R8: In framer loopback, `rx_framer_in` follows `tx_fmt_bit`, `rx_line_bit` is ignored, and `rx_clk_sel_tx`=1. Otherwise `rx_framer_in` follows `rx_line_bit` and `rx_clk_sel_tx`=0.
- R9: In framer loopback, `line_tx_out` is 1 when `cfg_e1`=0 and follows `tx_fmt_bit` when `cfg_e1`=1. Outside framer loopback it always follows `tx_fmt_bit`.
- R10: With both `cfg_pay_loop` and `cfg_frm_loop` set, only framer loopback acts and `loop_conflict`=1. Otherwise `loop_conflict`=0.
- R11: With no loopback, `tx_framer_in` is `tx_sig_in` when `tx_sig_ins`=1 and `tx_ser_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the window counter |
| cfg_e1 | input | 1 | 0 = T1, 1 = E1 |
| cfg_inv_sel | input | 2 | Inversion class select |
| cfg_lof_force | input | 1 | Force serial output high on loss of frame |
| cfg_pay_loop | input | 1 | Payload loopback enable |
| cfg_frm_loop | input | 1 | Framer loopback enable |
| rx_line_bit | input | 1 | Receive bit from line interface |
| rx_fr_bit | input | 1 | Decoded, violation-corrected receive bit |
| rx_cls_frm | input | 1 | Current receive bit is framing |
| rx_cls_sig | input | 1 | Current receive bit is signaling |
| rx_cls_pay | input | 1 | Current receive bit is payload |
| rx_lof | input | 1 | Receive frame alignment lost |
| rx_fsync | input | 1 | First bit of receive frame |
| rx_bit_en | input | 1 | Receive bit-time strobe |
| tx_ser_in | input | 1 | Transmit serial data |
| tx_sig_in | input | 1 | Transmit signaling data |
| tx_sig_ins | input | 1 | Take this bit from signaling input |
| tx_fsync_in | input | 1 | External transmit frame sync |
| tx_chclk_in | input | 1 | Transmit channel clock from timing |
| tx_chblk_in | input | 1 | Transmit channel block from timing |
| tx_fmt_bit | input | 1 | Formatted bit from transmit framer |
| rx_ser_out | output | 1 | Conditioned receive serial output |
| rx_framer_in | output | 1 | Bit to receive framer |
| rx_clk_sel_tx | output | 1 | Receive timing from transmit clock |
| tx_framer_in | output | 1 | Bit to transmit framer |
| tx_fsync_out | output | 1 | Frame sync to transmit framer |
| tx_clk_sel_rx | output | 1 | Transmit timing from receive clock |
| tx_chclk_out | output | 1 | Transmit channel clock output |
| tx_chblk_out | output | 1 | Transmit channel block output |
| line_tx_out | output | 1 | Bit to line transmitter |
| loop_conflict | output | 1 | Both loopbacks requested |

## Verification
The window counter is the only internal state. If it holds a wrong value, the error shows on `tx_framer_in` in payload loopback as a payload bit sent as 1 too early, or as real data sent past the 192nd or 248th bit. The error persists until the next `rx_fsync`, at most one frame later. The sweep runs frames longer than the window in both modes and inserts idle bit times. Counting errors and off-by-one errors at the window edge therefore appear within one frame.

// File: rtl/t1e1_loop_cond.sv
module t1e1_loop_cond #(
  parameter int T1_PAY_BITS = 192,
  parameter int E1_PAY_BITS = 248
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_e1,
  input  logic [1:0] cfg_inv_sel,
  input  logic       cfg_lof_force,
  input  logic       cfg_pay_loop,
  input  logic       cfg_frm_loop,
  input  logic       rx_line_bit,
  input  logic       rx_fr_bit,
  input  logic       rx_cls_frm,
  input  logic       rx_cls_sig,
  input  logic       rx_cls_pay,
  input  logic       rx_lof,
  input  logic       rx_fsync,
  input  logic       rx_bit_en,
  input  logic       tx_ser_in,
  input  logic       tx_sig_in,
  input  logic       tx_sig_ins,
  input  logic       tx_fsync_in,
  input  logic       tx_chclk_in,
  input  logic       tx_chblk_in,
  input  logic       tx_fmt_bit,
  output logic       rx_ser_out,
  output logic       rx_framer_in,
  output logic       rx_clk_sel_tx,
  output logic       tx_framer_in,
  output logic       tx_fsync_out,
  output logic       tx_clk_sel_rx,
  output logic       tx_chclk_out,
  output logic       tx_chblk_out,
  output logic       line_tx_out,
  output logic       loop_conflict
);

  localparam int MAX_PAY = (T1_PAY_BITS > E1_PAY_BITS) ? T1_PAY_BITS : E1_PAY_BITS;
  localparam int CW      = $clog2(MAX_PAY + 1);

  logic [CW-1:0] pay_cnt, pay_idx, pay_lim;
  logic          in_window, frm_on, pay_on, inv_hit, loop_bit;

  assign frm_on        = cfg_frm_loop;
  assign pay_on        = cfg_pay_loop & ~cfg_frm_loop;
  assign loop_conflict = cfg_pay_loop & cfg_frm_loop;

  assign pay_lim   = cfg_e1 ? CW'(E1_PAY_BITS) : CW'(T1_PAY_BITS);
  assign pay_idx   = rx_fsync ? '0 : pay_cnt;
  assign in_window = pay_idx < pay_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pay_cnt <= '0;
    else if (rx_bit_en) begin
      if (rx_cls_pay && in_window)
        pay_cnt <= pay_idx + CW'(1);
      else if (rx_fsync)
        pay_cnt <= '0;
    end
  end

  always_comb begin
    unique case (cfg_inv_sel)
      2'b01:   inv_hit = rx_cls_frm;
      2'b10:   inv_hit = rx_cls_sig;
      2'b11:   inv_hit = rx_cls_pay;
      default: inv_hit = 1'b0;
    endcase
  end

  assign rx_ser_out    = (cfg_lof_force & rx_lof) | (rx_fr_bit ^ inv_hit);
  assign rx_framer_in  = frm_on ? tx_fmt_bit : rx_line_bit;
  assign rx_clk_sel_tx = frm_on;

  assign loop_bit      = (rx_cls_pay & in_window) ? rx_fr_bit : 1'b1;
  assign tx_framer_in  = pay_on ? loop_bit : (tx_sig_ins ? tx_sig_in : tx_ser_in);
  assign tx_fsync_out  = pay_on ? rx_fsync : tx_fsync_in;
  assign tx_clk_sel_rx = pay_on;
  assign tx_chclk_out  = tx_chclk_in & ~pay_on;
  assign tx_chblk_out  = tx_chblk_in & ~pay_on;
  assign line_tx_out   = (frm_on & ~cfg_e1) | tx_fmt_bit;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_cnt <= CW'(MAX_PAY));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit_en && rx_cls_pay && !rx_fsync && pay_cnt < pay_lim) |=> (pay_cnt == $past(pay_cnt) + CW'(1)));

  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_en |=> $stable(pay_cnt));

  assert_lof_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lof_force && rx_lof) |-> rx_ser_out);

  assert_chan_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk_sel_rx |-> (!tx_chclk_out && !tx_chblk_out));

  assert_t1_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clk_sel_tx && !cfg_e1 |-> line_tx_out);

  assert_one_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_clk_sel_tx && tx_clk_sel_rx));

  assert_class_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_cls_frm, rx_cls_sig, rx_cls_pay}));

endmodule

// File: tb/t1e1_loop_cond_test.sv
module t1e1_loop_cond_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_e1 = 0, cfg_lof_force = 0, cfg_pay_loop = 0, cfg_frm_loop = 0;
  logic [1:0] cfg_inv_sel = 0;
  logic rx_line_bit = 0, rx_fr_bit = 0, rx_cls_frm = 0, rx_cls_sig = 0, rx_cls_pay = 0;
  logic rx_lof = 0, rx_fsync = 0, rx_bit_en = 0;
  logic tx_ser_in = 0, tx_sig_in = 0, tx_sig_ins = 0, tx_fsync_in = 0;
  logic tx_chclk_in = 0, tx_chblk_in = 0, tx_fmt_bit = 0;
  logic rx_ser_out, rx_framer_in, rx_clk_sel_tx, tx_framer_in, tx_fsync_out;
  logic tx_clk_sel_rx, tx_chclk_out, tx_chblk_out, line_tx_out, loop_conflict;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  t1e1_loop_cond uut (.*);

  task automatic chk(input string req, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cfg_pay_loop = 1; rx_cls_pay = 1; rx_fr_bit = 0;
    #2 chk("R5 reset window open", tx_framer_in, 1'b0);
    cfg_pay_loop = 0; rx_cls_pay = 0;
    rst_n = 1'b1;

    // R1 R2 R3: full sweep of inversion, class, data and loss-of-frame
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        for (int b = 0; b < 2; b++)
          for (int l = 0; l < 4; l++) begin
            logic inv, exp;
            @(negedge clk);
            cfg_inv_sel = 2'(s); rx_fr_bit = b[0];
            rx_cls_frm = (c == 1); rx_cls_sig = (c == 2); rx_cls_pay = (c == 3);
            rx_lof = l[0]; cfg_lof_force = l[1];
            inv = (s != 0) && (s == c);
            exp = (l[0] & l[1]) | (b[0] ^ inv);
            #2;
            if (l == 3) chk("R2 forced high", rx_ser_out, exp);
            else if (l == 1) chk("R3 lof ignored", rx_ser_out, exp);
            else chk("R1 inversion", rx_ser_out, exp);
          end
    rx_cls_frm = 0; rx_cls_sig = 0; rx_cls_pay = 0; cfg_lof_force = 0; rx_lof = 0; cfg_inv_sel = 0;

    // R4 R6-R11: every loop mode against every side input pattern
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 256; v++) begin
          logic pl, fl, en_pay, exp_tx;
          @(negedge clk);
          pl = m[0]; fl = m[1]; en_pay = pl & ~fl;
          cfg_pay_loop = pl; cfg_frm_loop = fl; cfg_e1 = e[0];
          rx_line_bit = v[0]; tx_fmt_bit = v[1]; tx_ser_in = v[2]; tx_sig_in = v[3];
          tx_sig_ins = v[4]; rx_fsync = v[5]; tx_fsync_in = v[6];
          tx_chclk_in = v[7]; tx_chblk_in = ~v[7]; rx_fr_bit = v[6];
          rx_cls_pay = v[2]; rx_bit_en = 1'b0;
          exp_tx = en_pay ? (v[2] ? v[6] : 1'b1) : (v[4] ? v[3] : v[2]);
          #2;
          if (en_pay) chk("R4 payload looped", tx_framer_in, exp_tx);
          else chk("R11 tx select", tx_framer_in, exp_tx);
          chk("R6 sync source", tx_fsync_out, en_pay ? v[5] : v[6]);
          chk("R6 tx clock select", tx_clk_sel_rx, en_pay);
          chk("R7 chclk", tx_chclk_out, en_pay ? 1'b0 : v[7]);
          chk("R7 chblk", tx_chblk_out, en_pay ? 1'b0 : ~v[7]);
          chk("R8 rx framer input", rx_framer_in, fl ? v[1] : v[0]);
          chk("R8 rx clock select", rx_clk_sel_tx, fl);
          chk("R9 line output", line_tx_out, (fl & ~e[0]) ? 1'b1 : v[1]);
          chk("R10 conflict", loop_conflict, pl & fl);
        end

    // R5: window length in both modes, idle bit times do not advance
    cfg_pay_loop = 1; cfg_frm_loop = 0; rx_cls_pay = 1;
    for (int e = 0; e < 2; e++)
      for (int fr = 0; fr < 2; fr++) begin
        int lim;
        lim = e ? 248 : 192;
        for (int k = 0; k < 262; k++) begin
          for (int idle = 0; idle < 2; idle++) begin
            if (idle == 1 && (k % 7) != 3) continue;
            @(negedge clk);
            cfg_e1 = e[0];
            rx_fsync = (k == 0) && (idle == 0);
            rx_bit_en = (idle == 0);
            rx_fr_bit = k[0];
            #2 chk("R5 window", tx_framer_in, (k < lim) ? k[0] : 1'b1);
          end
        end
      end

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule